// File: doc/BRIEF.md
# MSI Doorbell Interrupt Frame

This block is a 4 KB register frame on a simple register bus. It turns message-signalled interrupt writes into one-cycle pulses on a bank of interrupt lines that feed a shared interrupt controller. A master posts a write to the doorbell offset. The low ten bits of the write data carry an interrupt ID. The frame takes away its bias, which is the base line number plus 32. If the result lands inside the configured line count, the matching output line pulses for one clock.

Software discovers the frame through two read-only words. The type word packs the first interrupt ID served and the number of lines. The identification word carries a fixed product code. Every other offset, including the optional identification block at the top of the frame, reads as zero. Reads are honoured only for word accesses. Writes are honoured only for halfword and word accesses. The base and the line count are parameters, and their legal ranges are checked at elaboration.

Top module: `msi_doorbell_frame`

## Requirements
- R1: After reset, `irq_pulse` is all zeros and `bus_rdata` is zero.
- R2: A word read of offset 0x008 returns (BASE_LINE + 32) in bits [31:16] and LINE_COUNT in the low bits. `bus_rdata` is loaded on the clock edge that samples `bus_rd` and holds until the next read.
- R3: A word read of offset 0xFCC returns 0x0510_0000, which is product code 0x51 in bits [31:20] with the other fields zero.
- R4: A word read of any offset in 0xFD0..0xFFC, or of any offset other than 0x008 and 0xFCC, returns zero.
- R5: A read whose `bus_size` is not word (size codes: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes) returns zero.
- R6: A write to offset 0x040 with size code 1 or 2 takes ID = `bus_wdata[9:0]`, ignores `bus_wdata[31:10]`, and pulses line ID − (BASE_LINE + 32) in the cycle after the write edge.
- R7: A doorbell write whose ID is below BASE_LINE + 32, or at or above BASE_LINE + 32 + LINE_COUNT, pulses no line.
- R8: A write with size code 0 or 3, or a write to any offset other than 0x040, pulses no line.
- R9: Each accepted write raises exactly one line for exactly one cycle, and at most one line is high at a time. Two writes on consecutive cycles give two separate pulses.
- R10: Elaboration fails if LINE_COUNT is outside 1..128 or if BASE_LINE + 32 exceeds 1020 − LINE_COUNT.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte offset within the frame |
| bus_wdata | input | 32 | Write data |
| bus_size | input | 2 | Access size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, registered |
| irq_pulse | output | LINE_COUNT | One-cycle interrupt pulses, one bit per line |

## Verification
The assertions check on every cycle that at most one line is high, that no line pulses without a qualifying doorbell write one cycle earlier, that an ID below the bias never produces a pulse, and that non-word reads and type-word reads load the correct value. The bench scenarios are needed to show that the right line fires for IDs at and beyond both ends of the window, that back-to-back writes give two pulses, and that the identification and reserved offsets read correctly. Mixed random traffic with bad sizes and bad offsets shows that dropped accesses leave every line quiet.

// File: rtl/msi_frame_pkg.sv
package msi_frame_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_HALF  = 2'd1,
      SZ_WORD  = 2'd2,
      SZ_DWORD = 2'd3
   } acc_size_e;

   localparam int ADDR_W      = 12;
   localparam int DATA_W      = 32;
   localparam int ID_W        = 10;
   localparam int SPI_BIAS    = 32;
   localparam int ID_CEILING  = 1020;
   localparam int MAX_LINES   = 128;

   localparam logic [ADDR_W-1:0] OFS_TYPE     = 12'h008;
   localparam logic [ADDR_W-1:0] OFS_DOORBELL = 12'h040;
   localparam logic [ADDR_W-1:0] OFS_IDENT    = 12'hFCC;

   localparam logic [DATA_W-1:0] IDENT_VALUE  = 32'h51 << 20;

endpackage

// File: rtl/msi_read_decode.sv
module msi_read_decode
   import msi_frame_pkg::*;
#(
   parameter int BASE_LINE  = 0,
   parameter int LINE_COUNT = 64
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] value
);

   localparam logic [DATA_W-1:0] TYPE_VALUE =
      (DATA_W'(BASE_LINE + SPI_BIAS) << 16) | DATA_W'(LINE_COUNT);

   always_comb begin
      unique case (addr)
         OFS_TYPE:  value = TYPE_VALUE;
         OFS_IDENT: value = IDENT_VALUE;
         default:   value = '0;
      endcase
   end

endmodule

// File: rtl/msi_id_xlate.sv
module msi_id_xlate
   import msi_frame_pkg::*;
#(
   parameter int BASE_LINE  = 0,
   parameter int LINE_COUNT = 64,
   parameter int IDX_W      = 6
) (
   input  logic [ID_W-1:0]  id,
   output logic             hit,
   output logic [IDX_W-1:0] idx
);

   localparam int OFFSET = BASE_LINE + SPI_BIAS;

   logic [ID_W:0] diff;

   assign diff = {1'b0, id} - (ID_W+1)'(OFFSET);
   assign hit  = (id >= ID_W'(OFFSET)) && (diff < (ID_W+1)'(LINE_COUNT));

   generate
      if (LINE_COUNT == 1) begin : g_single
         assign idx = '0;
      end else begin : g_multi
         assign idx = diff[IDX_W-1:0];
      end
   endgenerate

endmodule

// File: rtl/msi_pulse_bank.sv
module msi_pulse_bank #(
   parameter int LINE_COUNT = 64,
   parameter int IDX_W      = 6
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  fire,
   input  logic [IDX_W-1:0]      idx,
   output logic [LINE_COUNT-1:0] pulse
);

   generate
      for (genvar g = 0; g < LINE_COUNT; g++) begin : g_line
         always_ff @(posedge clk) begin
            if (!rst_n) pulse[g] <= 1'b0;
            else        pulse[g] <= fire && (idx == IDX_W'(g));
         end

         // R6: a line pulses only when the previous cycle selected it
         p_line_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
            pulse[g] |-> $past(fire && (idx == IDX_W'(g))));
      end
   endgenerate

   // R9: never more than one line high
   p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pulse));

endmodule

// File: rtl/msi_doorbell_frame.sv
module msi_doorbell_frame
   import msi_frame_pkg::*;
#(
   parameter int BASE_LINE  = 0,
   parameter int LINE_COUNT = 64
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [11:0]           bus_addr,
   input  logic [31:0]           bus_wdata,
   input  logic [1:0]            bus_size,
   input  logic                  bus_wr,
   input  logic                  bus_rd,
   output logic [31:0]           bus_rdata,
   output logic [LINE_COUNT-1:0] irq_pulse
);

   localparam int IDX_W  = (LINE_COUNT > 1) ? $clog2(LINE_COUNT) : 1;
   localparam int OFFSET = BASE_LINE + SPI_BIAS;

   // R10: parameter legality
   generate
      if (LINE_COUNT < 1 || LINE_COUNT > MAX_LINES) begin : g_bad_count
         $error("msi_doorbell_frame: LINE_COUNT out of range");
      end
      if (BASE_LINE < 0 || OFFSET > ID_CEILING - LINE_COUNT) begin : g_bad_base
         $error("msi_doorbell_frame: BASE_LINE too large for LINE_COUNT");
      end
   endgenerate

   logic [DATA_W-1:0] dec_value;
   logic              id_hit;
   logic [IDX_W-1:0]  id_idx;
   logic              wr_ok;
   logic              fire;
   logic              unused_wdata_hi;

   assign unused_wdata_hi = ^bus_wdata[DATA_W-1:ID_W];

   msi_read_decode #(.BASE_LINE(BASE_LINE), .LINE_COUNT(LINE_COUNT)) u_dec (
      .addr  (bus_addr),
      .value (dec_value)
   );

   msi_id_xlate #(.BASE_LINE(BASE_LINE), .LINE_COUNT(LINE_COUNT), .IDX_W(IDX_W)) u_xlate (
      .id  (bus_wdata[ID_W-1:0]),
      .hit (id_hit),
      .idx (id_idx)
   );

   assign wr_ok = bus_wr && (bus_addr == OFS_DOORBELL) &&
                  (bus_size == SZ_HALF || bus_size == SZ_WORD);
   assign fire  = wr_ok && id_hit;

   msi_pulse_bank #(.LINE_COUNT(LINE_COUNT), .IDX_W(IDX_W)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (fire),
      .idx   (id_idx),
      .pulse (irq_pulse)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= (bus_size == SZ_WORD) ? dec_value : '0;
   end

   // R5: non-word reads load zero
   p_rd_size_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_size != SZ_WORD) |=> (bus_rdata == '0));

   // R2: type word contents
   p_type_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_size == SZ_WORD && bus_addr == OFS_TYPE) |=>
      (bus_rdata[31:16] == 16'(OFFSET) && bus_rdata[15:0] == 16'(LINE_COUNT)));

   // R8: any pulse needs a doorbell write of a legal size one cycle earlier
   p_no_stray_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_pulse) |-> $past(bus_wr && bus_addr == OFS_DOORBELL &&
                             (bus_size == SZ_HALF || bus_size == SZ_WORD)));

   // R7: an ID below the bias never pulses
   p_below_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == OFS_DOORBELL && bus_wdata[ID_W-1:0] < ID_W'(OFFSET))
      |=> (irq_pulse == '0));

endmodule

// File: tb/sim_msi_doorbell_frame.sv
module sim_msi_doorbell_frame;

   localparam int CLK_PERIOD = 10;
   localparam int BASE_LINE  = 0;
   localparam int LINE_COUNT = 64;
   localparam int OFFSET     = BASE_LINE + 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [1:0]  bus_size = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_rdata;
   logic [LINE_COUNT-1:0] irq_pulse;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   msi_doorbell_frame #(.BASE_LINE(BASE_LINE), .LINE_COUNT(LINE_COUNT)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_size(bus_size), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_rdata(bus_rdata), .irq_pulse(irq_pulse)
   );

   function automatic logic [63:0] exp_pulse(logic [11:0] a, logic [31:0] d, logic [1:0] s);
      int id;
      exp_pulse = '0;
      if (a != 12'h040 || !(s == 2'd1 || s == 2'd2)) return exp_pulse;
      id = int'(d[9:0]);
      if (id >= OFFSET && id - OFFSET < LINE_COUNT) exp_pulse = 64'd1 << (id - OFFSET);
   endfunction

   function automatic logic [31:0] exp_read(logic [11:0] a, logic [1:0] s);
      if (s != 2'd2) return 32'd0;
      if (a == 12'h008) return (32'(OFFSET) << 16) | 32'(LINE_COUNT);
      if (a == 12'hFCC) return 32'h51 << 20;
      return 32'd0;
   endfunction

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   // write: drive at negedge, captured at posedge, pulse visible at the next negedge
   task automatic do_write(string req, logic [11:0] a, logic [31:0] d, logic [1:0] s);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_size = s; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      check(req, 64'(irq_pulse), exp_pulse(a, d, s));
   endtask

   task automatic do_read(string req, logic [11:0] a, logic [1:0] s);
      @(negedge clk);
      bus_addr = a; bus_size = s; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      check(req, 64'(bus_rdata), 64'(exp_read(a, s)));
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      logic [31:0] r;
      r = $urandom(32'd20240611);
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 pulses", 64'(irq_pulse), 64'd0);
      check("R1 rdata", 64'(bus_rdata), 64'd0);
      rst_n = 1'b1;

      do_read("R2 type", 12'h008, 2'd2);
      check("R2 literal", 64'(bus_rdata), 64'h0020_0040);
      do_read("R3 ident", 12'hFCC, 2'd2);
      check("R3 literal", 64'(bus_rdata), 64'h0510_0000);
      do_read("R4 pidr low", 12'hFD0, 2'd2);
      do_read("R4 pidr2", 12'hFE8, 2'd2);
      do_read("R4 pidr top", 12'hFFC, 2'd2);
      do_read("R4 doorbell", 12'h040, 2'd2);
      do_read("R5 half", 12'h008, 2'd1);
      do_read("R5 byte", 12'hFCC, 2'd0);
      do_read("R5 dword", 12'h008, 2'd3);

      do_write("R7 below", 12'h040, 32'd31, 2'd2);
      do_write("R6 first", 12'h040, 32'd32, 2'd2);
      @(negedge clk);
      check("R9 one cycle", 64'(irq_pulse), 64'd0);
      do_write("R6 second", 12'h040, 32'd33, 2'd1);
      do_write("R6 last", 12'h040, 32'd95, 2'd2);
      do_write("R7 above", 12'h040, 32'd96, 2'd2);
      do_write("R7 above2", 12'h040, 32'd97, 2'd2);
      do_write("R6 hi bits", 12'h040, 32'hFFFF_FC00 | 32'd40, 2'd2);
      do_write("R8 byte", 12'h040, 32'd40, 2'd0);
      do_write("R8 dword", 12'h040, 32'd40, 2'd3);
      do_write("R8 offset", 12'h044, 32'd40, 2'd2);
      do_write("R8 type ofs", 12'h008, 32'd40, 2'd2);
      do_read("R8 type kept", 12'h008, 2'd2);

      // R9: back-to-back writes to one ID
      @(negedge clk);
      bus_addr = 12'h040; bus_wdata = 32'd50; bus_size = 2'd2; bus_wr = 1'b1;
      @(negedge clk);
      check("R9 b2b first", 64'(irq_pulse), 64'd1 << 18);
      @(negedge clk);
      bus_wr = 1'b0;
      check("R9 b2b second", 64'(irq_pulse), 64'd1 << 18);
      @(negedge clk);
      check("R9 b2b end", 64'(irq_pulse), 64'd0);

      for (int i = 0; i < 400; i++) begin
         int op = int'($urandom % 4);
         logic [1:0]  s = 2'($urandom % 4);
         logic [11:0] a;
         if (op < 3) begin
            logic [31:0] d = ($urandom & 32'hFFFF_FC00) | 32'(20 + $urandom % 100);
            a = ($urandom % 4 == 0) ? 12'(($urandom % 1024) * 4) : 12'h040;
            do_write("R6/R7/R8 random", a, d, s);
         end else begin
            case ($urandom % 4)
               0: a = 12'h008;
               1: a = 12'hFCC;
               2: a = 12'hFD0 + 12'(($urandom % 12) * 4);
               default: a = 12'(($urandom % 1024) * 4);
            endcase
            do_read("R2/R4/R5 random", a, s);
         end
      end

      @(negedge clk);
      summary();
   end

endmodule